// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing packets from memory into a device transmit FIFO. Software places packets on a circular list of two-word descriptors in memory and marks each loaded descriptor as owned by hardware. It then pulses a trigger input. The engine walks the list over a word-wide read/write memory port. For each owned descriptor, it streams the buffer's bytes to the FIFO with valid/last framing. It then writes the descriptor back with ownership cleared and pulses an interrupt.

Processing continues only while descriptors are owned by hardware. When the engine meets a descriptor that software still owns, it goes idle quietly and keeps that descriptor's address. The next trigger restarts from that descriptor, so the ring behaves as a producer/consumer queue. A bus error abandons the packet in flight and latches an error flag. The engine stops and stays stopped until it is triggered again.

Top module: `txring_dma`

## Requirements
- R1: After reset, busy_o, irq_o, err_o, tx_valid_o and mem_req_o are all low.
- R2: A kick_i pulse while idle raises busy_o on the next clock edge. The first trigger after reset fetches the descriptor at base_i.
- R3: A descriptor is two words. In word 0, bit 31 is ownership (1 = hardware), bit 30 is the wrap flag, and bits 15:0 are the byte length. Word 1, at the descriptor address + 4, holds a word-aligned buffer address. The buffer bytes reach the FIFO in ascending address order, least significant byte of each word first. tx_last_o is high on the final byte only.
- R4: While tx_valid_o is high and tx_ready_i is low, the byte and last flag hold stable. While a byte is pending, no memory request is issued.
- R5: After the final byte of a descriptor is accepted, word 0 is rewritten with bit 31 cleared and all other bits unchanged.
- R6: irq_o pulses for exactly one cycle per returned descriptor, in the cycle after its write-back completes.
- R7: Fetching a descriptor with bit 31 clear ends processing: no interrupt, no error, busy_o falls. The next trigger resumes at that same descriptor.
- R8: After a descriptor with the wrap flag set, the next descriptor is at base_i. Otherwise it is at the current address + 8.
- R9: A descriptor with length 0 is returned (write-back and interrupt) without any FIFO output.
- R10: A memory error aborts the current packet without a last byte, leaves that descriptor owned by hardware, sets err_o and stops the engine. err_o stays set until reset, and a later trigger retries the same descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_i | input | AW | Ring base address |
| kick_i | input | 1 | Transmit trigger pulse |
| busy_o | output | 1 | Engine processing the ring |
| irq_o | output | 1 | One-cycle descriptor completion pulse |
| err_o | output | 1 | Sticky memory error flag |
| mem_req_o | output | 1 | Memory request, held until ack or error |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with ack |
| mem_ack_i | input | 1 | Request completed |
| mem_err_i | input | 1 | Request failed |
| tx_valid_o | output | 1 | FIFO byte valid |
| tx_data_o | output | 8 | FIFO byte |
| tx_last_o | output | 1 | Final byte of a packet |
| tx_ready_i | input | 1 | FIFO can accept a byte |

## Verification
busy_o is registered, so it is due one edge after kick_i. The bench drives kick_i at a falling edge and samples busy_o at the next falling edge. The bench memory acknowledges in the same cycle it is asked, so each descriptor costs a fixed, short run of cycles. irq_o is due the cycle after the write-back acknowledge, and the bench counts its high samples and its longest run. Stream, ownership and error results are compared only after busy_o has fallen. Bytes and last flags are gathered only at edges where valid and ready are both high. Hold stability under backpressure is checked on every edge that follows a stalled cycle.

// File: rtl/txring_pkg.sv
package txring_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PTR,
        ST_FETCH,
        ST_SEND,
        ST_RETIRE
    } tx_state_e;
endpackage

// File: rtl/txring_byte_pick.sv
module txring_byte_pick #(
    parameter int DW   = 32,
    parameter int IDXW = $clog2(DW / 8)
) (
    input  logic [DW-1:0]   word_i,
    input  logic [IDXW-1:0] idx_i,
    output logic [7:0]      byte_o
);
    localparam int NB = DW / 8;

    logic [7:0] lanes [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = word_i[8*g +: 8];
    end

    assign byte_o = lanes[idx_i];
endmodule

// File: rtl/txring_next.sv
module txring_next #(
    parameter int AW     = 32,
    parameter int STRIDE = 8
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] base_i,
    input  logic          wrap_i,
    output logic [AW-1:0] next_o
);
    assign next_o = wrap_i ? base_i : cur_i + AW'(STRIDE);
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_i,
    input  logic          kick_i,
    output logic          busy_o,
    output logic          irq_o,
    output logic          err_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_ack_i,
    input  logic          mem_err_i,
    output logic          tx_valid_o,
    output logic [7:0]    tx_data_o,
    output logic          tx_last_o,
    input  logic          tx_ready_i
);
    localparam int BYTES    = DW / 8;
    localparam int IDXW     = $clog2(BYTES);
    localparam int STRIDE   = 2 * BYTES;
    localparam int OWN_POS  = DW - 1;
    localparam int WRAP_POS = DW - 2;

    typedef struct packed {
        tx_state_e       st;
        logic [AW-1:0]   cur;
        logic            fresh;
        logic [DW-1:0]   hdr;
        logic [AW-1:0]   ptr;
        logic [LW-1:0]   left;
        logic [DW-1:0]   word;
        logic [IDXW-1:0] idx;
        logic            irq;
        logic            err;
    } regs_t;

    regs_t q, d;
    logic [AW-1:0] next_desc;
    logic [7:0]    lane_byte;

    txring_next #(.AW(AW), .STRIDE(STRIDE)) u_next (
        .cur_i  (q.cur),
        .base_i (base_i),
        .wrap_i (q.hdr[WRAP_POS]),
        .next_o (next_desc)
    );

    txring_byte_pick #(.DW(DW)) u_pick (
        .word_i (q.word),
        .idx_i  (q.idx),
        .byte_o (lane_byte)
    );

    always_comb begin
        d           = q;
        d.irq       = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = q.cur;
        mem_wdata_o = q.hdr & ~(DW'(1) << OWN_POS);
        tx_valid_o  = 1'b0;
        tx_last_o   = 1'b0;
        tx_data_o   = lane_byte;

        case (q.st)
            ST_IDLE: begin
                if (kick_i) begin
                    d.st = ST_HDR;
                    if (q.fresh) begin
                        d.cur   = base_i;
                        d.fresh = 1'b0;
                    end
                end
            end
            ST_HDR: begin
                mem_req_o = 1'b1;
                if (mem_ack_i) begin
                    d.hdr  = mem_rdata_i;
                    d.left = mem_rdata_i[LW-1:0];
                    if (!mem_rdata_i[OWN_POS]) begin
                        d.st = ST_IDLE;
                    end else if (mem_rdata_i[LW-1:0] == '0) begin
                        d.st = ST_RETIRE;
                    end else begin
                        d.st = ST_PTR;
                    end
                end
            end
            ST_PTR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.cur + AW'(BYTES);
                if (mem_ack_i) begin
                    d.ptr = mem_rdata_i[AW-1:0] & ~AW'(BYTES - 1);
                    d.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.ptr;
                if (mem_ack_i) begin
                    d.word = mem_rdata_i;
                    d.idx  = '0;
                    d.ptr  = q.ptr + AW'(BYTES);
                    d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                tx_valid_o = 1'b1;
                tx_last_o  = (q.left == LW'(1));
                if (tx_ready_i) begin
                    d.left = q.left - LW'(1);
                    d.idx  = q.idx + IDXW'(1);
                    if (q.left == LW'(1)) begin
                        d.st = ST_RETIRE;
                    end else if (q.idx == IDXW'(BYTES - 1)) begin
                        d.st = ST_FETCH;
                    end
                end
            end
            ST_RETIRE: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                if (mem_ack_i) begin
                    d.irq = 1'b1;
                    d.cur = next_desc;
                    d.st  = ST_HDR;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (mem_req_o && mem_err_i) begin
            d.st  = ST_IDLE;
            d.err = 1'b1;
            d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.fresh <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != ST_IDLE);
    assign irq_o  = q.irq;
    assign err_o  = q.err;
endmodule

// File: rtl/txring_dma_sva.sv
module txring_dma_sva #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          kick_i,
    input logic          busy_o,
    input logic          irq_o,
    input logic          err_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          mem_ack_i,
    input logic          mem_err_i,
    input logic          tx_valid_o,
    input logic [7:0]    tx_data_o,
    input logic          tx_last_o,
    input logic          tx_ready_i
);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i && !busy_o |=> busy_o);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i && !mem_err_i |=>
            mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=>
            tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

    assert_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> !mem_req_o);

    assert_own_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> !mem_wdata_o[DW-1]);

    assert_irq_after_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_err_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o && !tx_valid_o);
endmodule

bind txring_dma txring_dma_sva #(.AW(AW), .DW(DW)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick_i      (kick_i),
    .busy_o      (busy_o),
    .irq_o       (irq_o),
    .err_o       (err_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_err_i   (mem_err_i),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_last_o   (tx_last_o),
    .tx_ready_i  (tx_ready_i)
);

// File: tb/txring_dma_test.sv
module txring_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = 32'h100;
    logic        kick_i = 1'b0;
    logic        busy_o, irq_o, err_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        mem_ack_i, mem_err_i;
    logic        tx_valid_o, tx_last_o;
    logic [7:0]  tx_data_o;
    logic        tx_ready_i;

    always #2 clk = ~clk;

    txring_dma uut (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .kick_i(kick_i),
        .busy_o(busy_o), .irq_o(irq_o), .err_o(err_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
        .tx_ready_i(tx_ready_i)
    );

    logic [31:0] mem [0:255];
    logic        fault_en = 1'b0;
    logic [31:0] fault_addr = '0;
    logic        bp_en = 1'b0;
    int          cyc = 0;

    always_comb begin
        mem_rdata_i = mem[mem_addr_o[9:2]];
        mem_err_i   = mem_req_o && fault_en && (mem_addr_o == fault_addr);
        mem_ack_i   = mem_req_o && !mem_err_i;
        tx_ready_i  = !bp_en || (cyc % 3 != 0);
    end

    logic [7:0] got [$];
    logic [7:0] exp_q [$];
    int lasts = 0, irqs = 0, irq_run = 0, irq_max = 0;
    int stalls = 0, stall_bad = 0;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic       prev_last = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_o && mem_we_o && mem_ack_i) mem[mem_addr_o[9:2]] <= mem_wdata_o;
        if (tx_valid_o && tx_ready_i) begin
            got.push_back(tx_data_o);
            if (tx_last_o) lasts++;
        end
        if (prev_stall && (!tx_valid_o || tx_data_o != prev_data || tx_last_o != prev_last))
            stall_bad++;
        prev_stall <= tx_valid_o && !tx_ready_i;
        if (tx_valid_o && !tx_ready_i) stalls++;
        prev_data <= tx_data_o;
        prev_last <= tx_last_o;
        if (irq_o) begin
            irqs++;
            irq_run++;
            if (irq_run + 1 > irq_max) irq_max = irq_run;
        end else begin
            irq_run = 0;
        end
    end

    int vectors = 0, fails = 0;

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    function automatic logic [31:0] hdr(int i, bit own, bit wrap, int len);
        return {own, wrap, 14'(12'h2A5 ^ i), 16'(len)};
    endfunction

    task automatic set_desc(int i, bit own, bit wrap, int len, int bufa);
        mem[64 + 2*i] = hdr(i, own, wrap, len);
        mem[65 + 2*i] = 32'(bufa);
    endtask

    task automatic expect_buf(int bufa, int len);
        for (int j = 0; j < len; j++) exp_q.push_back(pat(bufa + j));
    endtask

    task automatic clear_obs();
        got.delete();
        exp_q.delete();
        lasts = 0;
        irqs = 0;
        irq_max = 0;
        stalls = 0;
        stall_bad = 0;
    endtask

    task automatic kick_and_wait(string req);
        @(negedge clk);
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
        check({req, " busy one edge after trigger"}, int'(busy_o), 1);
        for (int n = 0; n < 3000 && busy_o; n++) @(negedge clk);
        check({req, " engine idle"}, int'(busy_o), 0);
        @(negedge clk);
    endtask

    task automatic compare_stream(string req);
        int bad = 0;
        check({req, " byte count"}, got.size(), exp_q.size());
        for (int k = 0; k < got.size() && k < exp_q.size(); k++)
            if (got[k] != exp_q[k]) bad++;
        check({req, " byte mismatches"}, bad, 0);
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy_o), 0);
        check("R1 irq", int'(irq_o), 0);
        check("R1 err", int'(err_o), 0);
        check("R1 tx_valid", int'(tx_valid_o), 0);
        check("R1 mem_req", int'(mem_req_o), 0);
    endtask

    task automatic t_basic();
        clear_obs();
        set_desc(0, 1, 0, 5, 'h200);
        set_desc(1, 1, 0, 8, 'h240);
        set_desc(2, 0, 0, 3, 'h280);
        expect_buf('h200, 5);
        expect_buf('h240, 8);
        kick_and_wait("R2");
        compare_stream("R3");
        check("R3 last count", lasts, 2);
        check("R5 desc0 returned", int'(mem[64] == hdr(0, 0, 0, 5)), 1);
        check("R5 desc1 returned", int'(mem[66] == hdr(1, 0, 0, 8)), 1);
        check("R7 desc2 untouched", int'(mem[68] == hdr(2, 0, 0, 3)), 1);
        check("R6 irq count", irqs, 2);
        check("R6 irq width", irq_max, 1);
        check("R7 no error at stop", int'(err_o), 0);
    endtask

    task automatic t_resume_wrap();
        clear_obs();
        set_desc(2, 1, 0, 3, 'h280);
        set_desc(3, 1, 1, 2, 'h2C0);
        set_desc(0, 1, 0, 1, 'h2E0);
        expect_buf('h280, 3);
        expect_buf('h2C0, 2);
        expect_buf('h2E0, 1);
        kick_and_wait("R7");
        compare_stream("R7 resume and R8 wrap");
        check("R8 last count", lasts, 3);
        check("R8 irq count", irqs, 3);
        check("R8 wrapped desc0 returned", int'(mem[64] == hdr(0, 0, 0, 1)), 1);
        check("R5 wrap flag kept", int'(mem[70] == hdr(3, 0, 1, 2)), 1);
    endtask

    task automatic t_backpressure_zero();
        clear_obs();
        set_desc(1, 1, 0, 7, 'h300);
        set_desc(2, 1, 0, 0, 'h380);
        expect_buf('h300, 7);
        bp_en = 1'b1;
        kick_and_wait("R4");
        bp_en = 1'b0;
        compare_stream("R4");
        check("R4 stalls seen", int'(stalls > 0), 1);
        check("R4 hold violations", stall_bad, 0);
        check("R9 irq count", irqs, 2);
        check("R9 zero length returned", int'(mem[68] == hdr(2, 0, 0, 0)), 1);
        check("R9 last count", lasts, 1);
    endtask

    task automatic t_error();
        clear_obs();
        set_desc(3, 1, 1, 8, 'h340);
        fault_en   = 1'b1;
        fault_addr = 32'h344;
        expect_buf('h340, 4);
        kick_and_wait("R10");
        compare_stream("R10 partial");
        check("R10 no last", lasts, 0);
        check("R10 no irq", irqs, 0);
        check("R10 err set", int'(err_o), 1);
        check("R10 desc kept", int'(mem[70] == hdr(3, 1, 1, 8)), 1);
        clear_obs();
        fault_en = 1'b0;
        expect_buf('h340, 8);
        kick_and_wait("R10");
        compare_stream("R10 retry");
        check("R10 retry last", lasts, 1);
        check("R10 err sticky", int'(err_o), 1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        for (int k = 0; k < 256; k++)
            mem[k] = {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)};
        for (int i = 0; i < 4; i++) set_desc(i, 0, i == 3, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_resume_wrap();
        t_backpressure_zero();
        t_error();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule